// File: doc/BRIEF.md
# Double-Buffered Configuration Byte Loader

This block is a byte-wide host write port that turns configuration bytes into a serial bit stream. A host addresses it with two chip selects of opposite polarity and moves one byte per write strobe. The data goes into a holding register. The holding register feeds a shift register, which sends the byte out one bit per clock, most significant bit first, with a bit-valid strobe beside it. Because the port has two stages, a new byte can wait in the holding register while the previous one is still being serialized, and the serial stream stays gap-free.

The host has two ways to pace its writes. It can poll a ready output, or it can read the same status on the top data bit. That bit is driven only when the port is selected, the write strobe is idle (high) and the read strobe is low. The lower seven data bits are inputs only. The asynchronous host strobes, selects and data pass through a two-flop synchronizer before the block uses them. A write that arrives while the holding register is occupied is dropped, and a sticky overrun flag records it.

Top module: `cfg_byte_loader`

## Requirements
- R1: A write is accepted only when `sel_n` is 0 and `sel` is 1 at the same time. With any other select combination a write strobe produces no serial bits, leaves `ready` high and does not set `overrun`.
- R2: The byte is taken from `bus_in[7:0]` on the rising (deasserting) edge of `wr_n`. The selects and the data must stay stable for two clocks after that edge. The selects may be released after every byte or held for a whole load.
- R3: `ready` goes low on the third rising clock edge after `wr_n` rises, and stays low while the holding register is occupied.
- R4: When the shift register is idle, the held byte moves to it on the next clock edge. `ready` is then low for exactly one cycle, and the first serial bit appears on the same edge at which `ready` returns high.
- R5: A byte written while the shift register is busy stays in the holding register, with `ready` low, until the current byte's last bit has been sent. Its first bit then follows on the very next cycle, so two such bytes form one contiguous 16-bit valid run.
- R6: `bus7_oe` is 1 exactly when `sel_n`=0, `sel`=1, `wr_n`=1 and `rd_n`=0, independent of the clock. While it is 1, `bus7_out` equals `ready`. The block has no drive on the lower seven data bits.
- R7: Each byte produces exactly 8 consecutive cycles with `bit_valid`=1, sending `bit_out` from bit 7 down to bit 0. `bit_valid` is 0 whenever no byte is being sent.
- R8: A write accepted while the holding register is occupied is discarded. The held byte is unchanged, and `overrun` becomes 1 and stays 1 until reset.
- R9: After reset, `ready`=1, `bit_valid`=0 and `overrun`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low chip select |
| sel | input | 1 | Active-high chip select |
| wr_n | input | 1 | Write strobe, active low; byte taken on its rising edge |
| rd_n | input | 1 | Read strobe, active low; output enable for the status bit |
| bus_in | input | 8 | Host data bus, input side |
| bus7_out | output | 1 | Ready status driven onto data bit 7 |
| bus7_oe | output | 1 | Output enable for data bit 7 |
| ready | output | 1 | 1 when another byte may be written |
| bit_out | output | 1 | Serial data, MSB first |
| bit_valid | output | 1 | 1 in each cycle that `bit_out` carries a bit |
| overrun | output | 1 | Sticky flag: a write was dropped while busy |

## Verification
A corrupted holding-register flag shows up at once at `ready` and `bus7_out`. Two cases are possible. If the flag is stuck clear, `ready` never drops on the third edge after a write. If it is stuck set, no byte ever reaches the serial output and the next write sets `overrun` within three clocks. A wrong shift count or a wrong shift direction shows within the 8 cycles of the byte's own valid run, as a run of the wrong length or as wrong bit values. A broken hand-over between the two registers shows as a gap or a merged run on `bit_valid`, within one cycle of the last bit of the earlier byte.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  // Port is addressed only when both selects agree.
  function automatic logic port_selected(input logic sel_n, input logic sel);
    return (!sel_n) && sel;
  endfunction

  // The shifter can take a new byte when idle or on its final bit.
  function automatic logic shifter_free(input int unsigned bits_left);
    return bits_left <= 1;
  endfunction

  // Status read-back enable: selected, write idle, read active.
  function automatic logic status_drive(input logic sel_n, input logic sel,
                                        input logic wr_n, input logic rd_n);
    return port_selected(sel_n, sel) && wr_n && !rd_n;
  endfunction

endpackage

// File: rtl/cfg_sync_chain.sv
module cfg_sync_chain #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= async_in;
      for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/cfg_hold_reg.sv
module cfg_hold_reg #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [DW-1:0] data_in,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] data_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full   <= 1'b0;
      data_q <= '0;
    end else if (capture && !full) begin
      full   <= 1'b1;
      data_q <= data_in;
    end else if (take) begin
      full   <= 1'b0;
    end
  end

  // A hand-over may only drain an occupied holding register.
  assert_take_needs_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full);

endmodule

// File: rtl/cfg_serializer.sv
module cfg_serializer #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  output logic          bit_out,
  output logic          bit_valid,
  output logic          free
);

  localparam int unsigned CW = $clog2(DW + 1);

  logic [DW-1:0] shift_q;
  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      left_q  <= '0;
    end else if (load) begin
      shift_q <= load_data;
      left_q  <= CW'(DW);
    end else if (left_q != '0) begin
      shift_q <= {shift_q[DW-2:0], 1'b0};
      left_q  <= left_q - CW'(1);
    end
  end

  assign bit_out   = shift_q[DW-1];
  assign bit_valid = (left_q != '0);
  assign free      = cfg_loader_pkg::shifter_free(int'(left_q));

  // One bit leaves per clock while a byte is in flight.
  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (left_q != '0 && !load) |=> (left_q == $past(left_q) - CW'(1)));

endmodule

// File: rtl/cfg_byte_loader.sv
module cfg_byte_loader #(
  parameter int unsigned DW = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          sel,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic [DW-1:0] bus_in,
  output logic          bus7_out,
  output logic          bus7_oe,
  output logic          ready,
  output logic          bit_out,
  output logic          bit_valid,
  output logic          overrun
);

  localparam int unsigned SW = DW + 2;
  localparam logic [SW-1:0] SYNC_RST = {1'b0, 1'b1, {DW{1'b0}}};

  logic          sel_raw;
  logic [SW-1:0] sync_q;
  logic          sel_s, wr_s, wr_prev;
  logic [DW-1:0] data_s;
  logic          wr_rise, write_ev, accept, drop, xfer;
  logic          hold_full, shift_free;
  logic [DW-1:0] hold_q;

  assign sel_raw = cfg_loader_pkg::port_selected(sel_n, sel);

  cfg_sync_chain #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({sel_raw, wr_n, bus_in}),
    .sync_out (sync_q)
  );

  assign {sel_s, wr_s, data_s} = sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_prev <= 1'b1;
    else        wr_prev <= wr_s;
  end

  // Named internal events
  assign wr_rise  = wr_s && !wr_prev;
  assign write_ev = wr_rise && sel_s;
  assign accept   = write_ev && !hold_full;
  assign drop     = write_ev && hold_full;
  assign xfer     = hold_full && shift_free;

  cfg_hold_reg #(.DW(DW)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (accept),
    .data_in (data_s),
    .take    (xfer),
    .full    (hold_full),
    .data_q  (hold_q)
  );

  cfg_serializer #(.DW(DW)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (xfer),
    .load_data (hold_q),
    .bit_out   (bit_out),
    .bit_valid (bit_valid),
    .free      (shift_free)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    overrun <= 1'b0;
    else if (drop) overrun <= 1'b1;
  end

  assign ready    = !hold_full;
  assign bus7_oe  = cfg_loader_pkg::status_drive(sel_n, sel, wr_n, rd_n);
  assign bus7_out = ready;

  // An accepted byte makes the port busy on the next edge.
  assert_capture_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready);

  // An idle shifter takes the held byte at once, MSB first.
  assert_fast_move_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && !bit_valid) |=> (bit_valid && ready && bit_out == $past(hold_q[DW-1])));

  // A dropped write leaves the held byte alone and raises the flag.
  assert_drop_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (hold_q == $past(hold_q) && overrun));

  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

endmodule

// File: tb/cfg_byte_loader_bench.sv
`timescale 1ns/1ps
module cfg_byte_loader_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, sel = 1'b0, wr_n = 1'b1, rd_n = 1'b1;
  logic [7:0] bus_in = 8'h00;
  logic bus7_out, bus7_oe, ready, bit_out, bit_valid, overrun;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cfg_byte_loader u_cfg_byte_loader (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel(sel), .wr_n(wr_n), .rd_n(rd_n),
    .bus_in(bus_in), .bus7_out(bus7_out), .bus7_oe(bus7_oe), .ready(ready),
    .bit_out(bit_out), .bit_valid(bit_valid), .overrun(overrun)
  );

  // Serial monitor: assembles bytes and counts valid runs
  logic [7:0] got [$];
  int segs = 0;
  int nbits = 0;
  logic [7:0] acc = 8'h00;
  logic prev_v = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      nbits = 0;
      prev_v = 1'b0;
    end else begin
      if (bit_valid && !prev_v) segs = segs + 1;
      if (bit_valid) begin
        acc = {acc[6:0], bit_out};
        nbits = nbits + 1;
        if (nbits == 8) begin
          got.push_back(acc);
          nbits = 0;
        end
      end
      prev_v = bit_valid;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // Write strobe held low for low_len cycles, then released
  task automatic pulse(input logic [7:0] v, input logic csn, input logic cs1, input int low_len);
    sel_n = csn;
    sel = cs1;
    bus_in = v;
    wr_n = 1'b0;
    repeat (low_len) @(negedge clk);
    wr_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
  end

  initial begin
    int base;
    int s0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(ready == 1'b1, "R9 ready", ready, 1);
    check(bit_valid == 1'b0, "R9 bit_valid", bit_valid, 0);
    check(overrun == 1'b0, "R9 overrun", overrun, 0);

    // R2 R3 R4 R7: every byte value, selects cycled per byte
    for (int v = 0; v < 256; v++) begin
      base = got.size();
      s0 = segs;
      pulse(8'(v), 1'b0, 1'b1, 3);
      repeat (3) @(negedge clk);
      check(ready == 1'b0, "R3 busy after write", ready, 0);
      @(negedge clk);
      check(ready && bit_valid && bit_out == v[7], "R4 immediate move",
            {29'd0, ready, bit_valid, bit_out}, {29'd0, 2'b11, v[7]});
      repeat (10) @(negedge clk);
      check(got.size() == base + 1, "R2 byte count", got.size() - base, 1);
      if (got.size() == base + 1)
        check(got[base] == 8'(v), "R2 R7 byte value", got[base], v);
      check(segs == s0 + 1 && !bit_valid, "R7 single 8-bit run", segs - s0, 1);
      sel_n = 1'b1;
      sel = 1'b0;
      @(negedge clk);
    end

    // R1: non-selecting combinations
    for (int c = 0; c < 3; c++) begin
      logic csn_v, cs_v;
      csn_v = (c != 1);
      cs_v = (c == 0);
      base = got.size();
      pulse(8'hA5, csn_v, cs_v, 3);
      repeat (14) @(negedge clk);
      check(got.size() == base && ready && !overrun, "R1 ignored write",
            got.size() - base, 0);
      sel_n = 1'b1;
      sel = 1'b0;
      @(negedge clk);
    end

    // R6: status read-back enable, write strobe idle
    for (int c = 0; c < 8; c++) begin
      logic exp_oe;
      sel_n = c[0];
      sel = c[1];
      rd_n = c[2];
      #1;
      exp_oe = !c[0] && c[1] && !c[2];
      check(bus7_oe == exp_oe, "R6 oe wr high", bus7_oe, exp_oe);
      if (exp_oe) check(bus7_out == ready, "R6 status value", bus7_out, ready);
      @(negedge clk);
    end
    rd_n = 1'b1;
    sel_n = 1'b1;
    sel = 1'b0;
    @(negedge clk);
    // R6: never enabled while the write strobe is low
    wr_n = 1'b0;
    for (int c = 0; c < 8; c++) begin
      sel_n = c[0];
      sel = c[1];
      rd_n = c[2];
      #1;
      check(bus7_oe == 1'b0, "R6 oe wr low", bus7_oe, 0);
    end
    rd_n = 1'b1;
    sel_n = 1'b1;
    sel = 1'b0;
    repeat (4) @(negedge clk);
    base = got.size();
    wr_n = 1'b1;
    repeat (14) @(negedge clk);
    check(got.size() == base && !overrun, "R6 sweep wrote nothing", got.size() - base, 0);

    // R5 R8: A, B back to back, then C while B waits; selects held
    base = got.size();
    s0 = segs;
    pulse(8'h3C, 1'b0, 1'b1, 3);        // at negedge n
    repeat (2) @(negedge clk);          // n+2
    pulse(8'hC5, 1'b0, 1'b1, 3);        // rises at n+5
    @(negedge clk);                     // n+6
    pulse(8'h7E, 1'b0, 1'b1, 2);        // rises at n+8
    repeat (2) @(negedge clk);          // n+10
    check(ready == 1'b0, "R5 held while shifting", ready, 1'b0);
    check(overrun == 1'b0, "R8 flag not yet set", overrun, 0);
    rd_n = 1'b0;
    #1;
    check(bus7_oe == 1'b1 && bus7_out == 1'b0, "R6 busy read-back",
          {30'd0, bus7_oe, bus7_out}, 2);
    rd_n = 1'b1;
    @(negedge clk);                     // n+11
    check(overrun == 1'b1, "R8 overrun set", overrun, 1);
    @(negedge clk);                     // n+12
    check(ready == 1'b1, "R5 ready after last bit", ready, 1);
    repeat (20) @(negedge clk);
    check(got.size() == base + 2, "R8 dropped byte count", got.size() - base, 2);
    if (got.size() == base + 2) begin
      check(got[base] == 8'h3C, "R5 first byte", got[base], 8'h3C);
      check(got[base+1] == 8'hC5, "R8 held byte kept", got[base+1], 8'hC5);
    end
    check(segs == s0 + 1, "R5 contiguous 16-bit run", segs - s0, 1);
    check(overrun == 1'b1, "R8 sticky", overrun, 1);
    sel_n = 1'b1;
    sel = 1'b0;

    // R9: reset clears the flag
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(overrun == 1'b0 && ready == 1'b1 && bit_valid == 1'b0, "R9 reset again",
          {29'd0, overrun, ready, bit_valid}, 2);
    report();
  end

endmodule